// File: doc/BRIEF.md
# Dual-Strategy Conversion Search Controller

This controller runs the digital half of an analog-to-digital conversion. It drives a code into an external DAC and reads back one comparator bit per clock. From those decisions it builds an N-bit result. N is a parameter and defaults to 8. The DAC, the comparator and any sample-and-hold stage sit outside the block.

Each conversion uses one of two search strategies. The `mode_i` level at the moment of the start pulse picks the strategy:

- **Counting mode** climbs the code one step per clock, starting from zero. It stops as soon as the estimate is no longer below the input.
- **Successive-approximation mode** resolves the code one bit per clock, from the top bit down.

When a conversion ends, the block loads the result register and gives a one-cycle done pulse. The result then holds until the next conversion finishes.

Top module: `conv_search_ctrl`

## Requirements
- R1: While `rst_n` is low and after its release, `busy_o`, `done_o`, `dac_code_o` and `result_o` are all zero.
- R2: A `start_i` high while idle starts a conversion on that clock edge. `busy_o` is high from the following cycle until the conversion ends. A `start_i` while busy is ignored: the running conversion's result and length are unchanged.
- R3: The strategy is taken from `mode_i` only at the accepted start. `mode_i` = 1 selects successive approximation and `mode_i` = 0 selects counting. Changes of `mode_i` during a conversion have no effect.
- R4: In successive-approximation mode, the first code driven after start has only bit N-1 set.
- R5: In successive-approximation mode, each cycle samples `cmp_i` against the code presently driven. When `cmp_i` is 1 (input above the estimate), the bit under trial stays set; otherwise it is cleared. The next lower bit is then set for trial. With an ideal comparator, the result is the largest code strictly below the input. For an input of 5/15 of full scale with N = 8, the result is 01010101.
- R6: A successive-approximation conversion keeps `busy_o` high for exactly N cycles.
- R7: In counting mode, the code is 0 in the first busy cycle and rises by exactly one in every following busy cycle.
- R8: In counting mode, the conversion ends at the first code whose sampled `cmp_i` is 0. That code becomes the result, so `busy_o` lasts result+1 cycles.
- R9: In counting mode, if `cmp_i` is still 1 at the all-ones code, the conversion ends there with the all-ones result and a done pulse.
- R10: `done_o` is a single-cycle pulse in the first cycle after `busy_o` falls. `result_o` changes only together with a done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Conversion request, sampled each cycle |
| mode_i | input | 1 | Strategy select: 1 successive approximation, 0 counting |
| cmp_i | input | 1 | Comparator, 1 when the input exceeds the DAC estimate |
| dac_code_o | output | N | Code driven to the DAC |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle end-of-conversion pulse |
| result_o | output | N | Last conversion result |

## Verification
The embedded assertions check, on every cycle, the properties that need no model of the input:

- the done pulse is one cycle long and coincides with the end of busy;
- the result stays still between done pulses;
- the successive-approximation search opens at the top bit and runs exactly N cycles;
- the counting ramp steps by one.

Only the bench scenarios can show that the final codes are right. This covers the keep-or-clear decisions against a real input, the stopping code, saturation, and the indifference to starts and mode changes mid-conversion. The bench uses an ideal comparator model with quarter-LSB input resolution and sweeps the input across the full range and beyond in both modes.

// File: rtl/conv_search_ctrl.sv
module conv_search_ctrl #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         mode_i,
  input  logic         cmp_i,
  output logic [N-1:0] dac_code_o,
  output logic         busy_o,
  output logic         done_o,
  output logic [N-1:0] result_o
);

  localparam logic [N-1:0] TOP  = {1'b1, {(N-1){1'b0}}};
  localparam logic [N-1:0] ONES = '1;
  localparam int           LW   = N + 1;

  logic         busy_q, sar_q, done_q;
  logic [N-1:0] code_q, trial_q, res_q;

  logic [N-1:0] kept;
  logic         sar_last, ramp_end, finish;
  logic [N-1:0] final_code;

  assign kept       = cmp_i ? code_q : (code_q & ~trial_q);
  assign sar_last   = trial_q[0];
  assign ramp_end   = !cmp_i || (code_q == ONES);
  assign finish     = busy_q && (sar_q ? sar_last : ramp_end);
  assign final_code = sar_q ? kept : code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      sar_q   <= 1'b0;
      done_q  <= 1'b0;
      code_q  <= '0;
      trial_q <= '0;
      res_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q  <= 1'b1;
          sar_q   <= mode_i;
          code_q  <= mode_i ? TOP : '0;
          trial_q <= TOP;
        end
      end else if (finish) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        res_q  <= final_code;
      end else if (sar_q) begin
        code_q  <= kept | (trial_q >> 1);
        trial_q <= trial_q >> 1;
      end else begin
        code_q <= code_q + 1'b1;
      end
    end
  end

  assign dac_code_o = code_q;
  assign busy_o     = busy_q;
  assign done_o     = done_q;
  assign result_o   = res_q;

  logic [LW-1:0] len_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 len_q <= '0;
    else if (!busy_q && start_i) len_q <= '0;
    else if (busy_q)            len_q <= len_q + 1'b1;
  end

  AST_DONE_AT_BUSY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)));  // R10
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);  // R10
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(result_o));  // R10
  AST_SAR_TOP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy_o) && sar_q) |-> (dac_code_o == TOP));  // R4
  AST_SAR_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && sar_q) |-> (len_q == LW'(N)));  // R6
  AST_RAMP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy_o) && !sar_q) |-> (dac_code_o == '0));  // R7
  AST_RAMP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o) && !sar_q) |-> (dac_code_o == $past(dac_code_o) + 1'b1));  // R7

endmodule

// File: tb/conv_search_ctrl_tb.sv
`timescale 1ns/1ps
module conv_search_ctrl_tb;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_i = 1'b0;
  logic         mode_i = 1'b0;
  logic [11:0]  vin = '0;
  logic         cmp_i;
  logic [N-1:0] dac_code_o, result_o;
  logic         busy_o, done_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign cmp_i = vin > {2'b00, dac_code_o, 2'b00};

  conv_search_ctrl #(.N(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i), .cmp_i(cmp_i),
    .dac_code_o(dac_code_o), .busy_o(busy_o), .done_o(done_o), .result_o(result_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (vin=%0d)", req, act, exp, vin);
    end
  endtask

  function automatic int sar_exp(input int v);
    int c;
    if (v == 0) return 0;
    c = (v - 1) >> 2;
    return (c > 255) ? 255 : c;
  endfunction

  function automatic int cnt_exp(input int v);
    int c;
    c = (v + 3) >> 2;
    return (c > 255) ? 255 : c;
  endfunction

  task automatic convert(input bit sar, input int v, input bit disturb);
    int n, exp, k;
    bit seen;
    vin = 12'(v);
    @(negedge clk);
    mode_i  = sar;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    mode_i  = ~sar;
    if (sar) chk("R4", dac_code_o, 128);
    else     chk("R7", dac_code_o, 0);
    chk("R2", busy_o, 1);
    n = 0; seen = 0; k = 0;
    while (!seen && k < 400) begin
      if (disturb && k == 2) start_i = 1'b1;
      if (busy_o) n++;
      if (!sar && busy_o && k == 1) chk("R7", dac_code_o, (cnt_exp(v) >= 1) ? 1 : 0);
      if (done_o) seen = 1;
      else begin
        @(negedge clk);
        start_i = 1'b0;
        k++;
      end
    end
    if (!seen) begin
      chk("R10", 0, 1);
      return;
    end
    exp = sar ? sar_exp(v) : cnt_exp(v);
    chk("R10", busy_o, 0);
    if (sar) begin
      chk("R5", result_o, exp);
      chk("R6", n, N);
    end else begin
      chk((v > 1020) ? "R9" : "R8", result_o, exp);
      chk("R8", n, exp + 1);
    end
    if (disturb) chk("R3", result_o, exp);
    vin = 12'(4095 - v);
    @(negedge clk);
    chk("R10", done_o, 0);
    chk("R10", result_o, exp);
    mode_i = 1'b0;
  endtask

  initial begin
    #1;
    chk("R1", {busy_o, done_o}, 0);
    chk("R1", result_o, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", {busy_o, done_o}, 0);
    chk("R1", dac_code_o, 0);
    chk("R1", result_o, 0);
    convert(1'b1, 341, 1'b0);
    chk("R5", result_o, 8'b01010101);
    for (int v = 0; v <= 1100; v++) convert(1'b1, v, 1'b0);
    for (int v = 0; v <= 1100; v += 3) convert(1'b0, v, 1'b0);
    convert(1'b0, 1020, 1'b0);
    convert(1'b0, 1021, 1'b0);
    convert(1'b0, 4095, 1'b0);
    convert(1'b1, 4095, 1'b0);
    for (int v = 100; v < 1100; v += 97) begin
      convert(1'b1, v, 1'b1);
      convert(1'b0, v, 1'b1);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    wait (cyc > 190000);
    fails++;
    checks++;
    $display("FAIL watchdog R2 actual=%0d expected=%0d", cyc, 190000);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule